// File: doc/BRIEF.md
# Sub-band Sample Serial Link

This block is the clock-master end of a stereo serial link that moves 24-bit sub-band samples between two chips. A system-clock enable drives it. Each enabled cycle flips the bit clock. Sixty-four bit clocks make one word-select frame: the left half while word select is low, the right half while it is high. Each half holds a 32-slot word. Slot 0 is a one-bit lag, slots 1 to 24 carry the sample with the most significant bit first, and the remaining slots are padding.

Transmit pairs come in through a valid/ready port backed by a one-deep holding register. The serializer takes that register at the falling bit-clock edge that opens a frame. A sender that misses a frame sees its previous pair sent again and a sticky underrun flag. The receiver samples the serial input on rising bit-clock edges. Once the right-channel LSB is in, it presents the pair and its sub-band index on a valid/ready output port. That port holds a pair until it is taken. A pair not yet taken when the next one is complete is replaced by the newer pair, because the link cannot stall.

A frame counter cycles through 32 sub-bands. A frame-sync output is high for the whole frame that carries sub-band 0.

Top module: `subband_link`

## Requirements
- R1: `sclk` toggles on each clock with `ce` high and holds while `ce` is low. After reset `sclk` is 0, so the first enabled cycle is a rising edge and the second is the falling edge that opens frame 0.
- R2: `ws` and `sdo` change only in cycles where `sclk` falls.
- R3: Each frame is 64 bit clocks, counted from the falling edge that opens it. `ws` is 0 for slots 0 to 31 (left) and 1 for slots 32 to 63 (right). In each half, slot 1 carries sample bit 23 and slot 24 carries bit 0.
- R4: The transmitter drives slot 0 and slots 25 to 31 of each half to 0. Read MSB first, a half is {0, sample[23:0], 7'b0}.
- R5: `sdi` is sampled on rising `sclk` edges. In the cycle after the right-channel bit 0 is sampled, `rx_valid` rises with `rx_left`, `rx_right` and `rx_band` set to that frame's data and index. With `sdo` looped to `sdi`, frame k returns the k-th pushed pair.
- R6: The sub-band index starts at 0 in the first frame after reset and counts 0 to 31, then wraps to 0. `fsync` is 1 for exactly the frames with index 0, changing on the frame-opening falling edge.
- R7: `tx_ready` is 1 while the holding register is empty. A handshake fills it. It is emptied at the next frame-opening falling edge, and that frame carries the pair.
- R8: If the holding register is empty when a frame opens, the previous pair is sent again and `underrun` goes to 1. It stays 1 until reset.
- R9: While `rx_ready` is 0, `rx_valid` stays 1 and the pair holds, unless the next frame completes, which replaces it. A handshake clears `rx_valid` one clock later.
- R10: Reset is synchronous and active high. It sets `sclk`, `ws`, `sdo`, `fsync`, `rx_valid` and `underrun` to 0, `rx_band` to 0 and `tx_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; each pulse is one half bit clock |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Holding register empty |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Consumer takes the received pair |
| rx_left | output | 24 | Received left sample |
| rx_right | output | 24 | Received right sample |
| rx_band | output | 5 | Sub-band index of the received frame |
| underrun | output | 1 | Sticky flag: a frame opened with no new pair |
| sclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 = left half |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| fsync | output | 1 | High during the sub-band 0 frame |

## Verification
A slot counter off by one shows within one half-frame. The sample appears shifted by a bit on `sdo`, and after loopback the received words come back doubled or halved, already in frame 0. A wrong frame counter gives a wrong `rx_band` on the first received pair. It also leaves `fsync` low in the first frame or high in the second. A holding register that fails to empty or refill shows one frame later, as a repeated pair on the receive port and an early `underrun`.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  // True when a slot position inside a half-frame carries payload.
  function automatic logic in_payload(input int pos, input int last);
    return (pos >= 1) && (pos <= last);
  endfunction
endpackage

// File: rtl/sbl_timing.sv
module sbl_timing #(
  parameter int SLOT_W = 32,
  parameter int BANDS  = 32,
  parameter int SIW    = $clog2(2 * SLOT_W),
  parameter int BW     = $clog2(BANDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  output logic           sclk_o,
  output logic           rise_o,
  output logic           fall_o,
  output logic           frame_start_o,
  output logic [SIW-1:0] slot_o,
  output logic [SIW-1:0] slot_nxt_o,
  output logic [BW-1:0]  band_o,
  output logic           ws_o,
  output logic           fsync_o
);
  localparam logic [SIW-1:0] SLOT_LAST = SIW'(2 * SLOT_W - 1);
  localparam logic [BW-1:0]  BAND_LAST = BW'(BANDS - 1);

  logic           sclk_q, ws_q, fsync_q;
  logic [SIW-1:0] slot_q, slot_nxt;
  logic [BW-1:0]  band_q, band_nxt;

  always_comb begin
    slot_nxt = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    band_nxt = (band_q == BAND_LAST) ? '0 : band_q + 1'b1;
  end

  assign rise_o        = ce & ~sclk_q;
  assign fall_o        = ce & sclk_q;
  assign frame_start_o = fall_o && (slot_q == SLOT_LAST);

  // Counters are preset to their last values so the first frame is slot 0, band 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      slot_q  <= SLOT_LAST;
      band_q  <= BAND_LAST;
      ws_q    <= 1'b0;
      fsync_q <= 1'b0;
    end else begin
      if (ce) sclk_q <= ~sclk_q;
      if (fall_o) begin
        slot_q <= slot_nxt;
        ws_q   <= slot_nxt[SIW-1];
        if (slot_q == SLOT_LAST) begin
          band_q  <= band_nxt;
          fsync_q <= (band_nxt == '0);
        end
      end
    end
  end

  assign sclk_o     = sclk_q;
  assign slot_o     = slot_q;
  assign slot_nxt_o = slot_nxt;
  assign band_o     = band_q;
  assign ws_o       = ws_q;
  assign fsync_o    = fsync_q;
endmodule

// File: rtl/sbl_tx.sv
module sbl_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int SIW      = $clog2(2 * SLOT_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_i,
  input  logic                frame_start_i,
  input  logic [SIW-1:0]      slot_nxt_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                sdo_o,
  output logic                underrun_o
);
  import sbl_pkg::*;
  localparam int POS_W = SIW - 1;
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SAMPLE_W);

  logic                pend_full, underrun_q, sdo_q, accept;
  logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r, word;
  logic [POS_W-1:0]    pos_n;
  logic                ch_n, bit_n;
  logic [IDX_W-1:0]    idx_n;

  assign tx_ready_o = ~pend_full;
  assign accept     = tx_valid_i & ~pend_full;
  assign pos_n      = slot_nxt_i[POS_W-1:0];
  assign ch_n       = slot_nxt_i[POS_W];

  always_comb begin
    word  = ch_n ? cur_r : cur_l;
    idx_n = IDX_W'(LAST_POS - pos_n);
    bit_n = in_payload(int'(pos_n), SAMPLE_W) ? word[idx_n] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_full  <= 1'b0;
      underrun_q <= 1'b0;
      sdo_q      <= 1'b0;
      pend_l     <= '0;
      pend_r     <= '0;
      cur_l      <= '0;
      cur_r      <= '0;
    end else begin
      if (frame_start_i) begin
        if (pend_full) begin
          cur_l     <= pend_l;
          cur_r     <= pend_r;
          pend_full <= 1'b0;
        end else begin
          underrun_q <= 1'b1;
        end
      end
      if (accept) begin
        pend_l    <= tx_left_i;
        pend_r    <= tx_right_i;
        pend_full <= 1'b1;
      end
      if (fall_i) sdo_q <= bit_n;
    end
  end

  assign sdo_o      = sdo_q;
  assign underrun_o = underrun_q;
endmodule

// File: rtl/sbl_rx.sv
module sbl_rx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int BANDS    = 32,
  parameter int SIW      = $clog2(2 * SLOT_W),
  parameter int BW       = $clog2(BANDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_i,
  input  logic [SIW-1:0]      slot_i,
  input  logic [BW-1:0]       band_i,
  input  logic                sdi_i,
  output logic                rx_valid_o,
  input  logic                rx_ready_i,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic [BW-1:0]       rx_band_o
);
  import sbl_pkg::*;
  localparam int POS_W = SIW - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh, sh_nxt, hold_l, out_l, out_r;
  logic [BW-1:0]       out_band;
  logic                valid_q, take;
  logic [POS_W-1:0]    pos;
  logic                ch;

  assign pos    = slot_i[POS_W-1:0];
  assign ch     = slot_i[POS_W];
  assign sh_nxt = {sh[SAMPLE_W-2:0], sdi_i};
  assign take   = rise_i && in_payload(int'(pos), SAMPLE_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      hold_l   <= '0;
      out_l    <= '0;
      out_r    <= '0;
      out_band <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (take) sh <= sh_nxt;
      if (take && pos == LAST_POS && !ch) hold_l <= sh_nxt;
      if (take && pos == LAST_POS && ch) begin
        out_l    <= hold_l;
        out_r    <= sh_nxt;
        out_band <= band_i;
        valid_q  <= 1'b1;
      end else if (valid_q && rx_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_left_o  = out_l;
  assign rx_right_o = out_r;
  assign rx_band_o  = out_band;
endmodule

// File: rtl/subband_link.sv
module subband_link #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int BANDS    = 32,
  parameter int BW       = $clog2(BANDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic [BW-1:0]       rx_band,
  output logic                underrun,
  output logic                sclk,
  output logic                ws,
  output logic                sdo,
  input  logic                sdi,
  output logic                fsync
);
  localparam int SIW = $clog2(2 * SLOT_W);

  logic           rise, fall, frame_start;
  logic [SIW-1:0] slot, slot_nxt;
  logic [BW-1:0]  band;

  sbl_timing #(.SLOT_W(SLOT_W), .BANDS(BANDS), .SIW(SIW), .BW(BW)) u_timing (
    .clk(clk), .rst(rst), .ce(ce),
    .sclk_o(sclk), .rise_o(rise), .fall_o(fall), .frame_start_o(frame_start),
    .slot_o(slot), .slot_nxt_o(slot_nxt), .band_o(band),
    .ws_o(ws), .fsync_o(fsync)
  );

  sbl_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .SIW(SIW)) u_tx (
    .clk(clk), .rst(rst), .fall_i(fall), .frame_start_i(frame_start),
    .slot_nxt_i(slot_nxt), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_left_i(tx_left), .tx_right_i(tx_right),
    .sdo_o(sdo), .underrun_o(underrun)
  );

  sbl_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .BANDS(BANDS), .SIW(SIW), .BW(BW)) u_rx (
    .clk(clk), .rst(rst), .rise_i(rise), .slot_i(slot), .band_i(band),
    .sdi_i(sdi), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_left_o(rx_left), .rx_right_o(rx_right), .rx_band_o(rx_band)
  );
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic sclk,
  input logic ws,
  input logic sdo,
  input logic fsync,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic underrun
);
  assert_sclk_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(sclk));

  assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws) |-> $fell(sclk));

  assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $fell(sclk));

  assert_fsync_left_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> (!ws && $fell(sclk)));

  assert_ready_at_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> $fell(sclk));

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(underrun) |-> underrun);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);
endmodule

bind subband_link sbl_checker u_chk (
  .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .ws(ws), .sdo(sdo),
  .fsync(fsync), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .underrun(underrun)
);

// File: tb/subband_link_tb.sv
module subband_link_tb;
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    48'h800001_7FFFFE, 48'hA5A5A5_5A5A5A, 48'h000000_FFFFFF, 48'h123456_ABCDEF,
    48'hFFFFFF_000001, 48'h0F0F0F_F0F0F0, 48'h800000_000001, 48'hC3C3C3_3C3C3C
  };

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic tx_ready, rx_valid, underrun, sclk, ws, sdo, fsync;
  logic [23:0] rx_left, rx_right;
  logic [4:0] rx_band;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  subband_link u_dut (
    .clk(clk), .rst(rst), .ce(ce), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_left(tx_left), .tx_right(tx_right), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right),
    .rx_band(rx_band), .underrun(underrun), .sclk(sclk), .ws(ws),
    .sdo(sdo), .sdi(sdo), .fsync(fsync)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [47:0] v);
    bit ok;
    tx_left  = v[47:24];
    tx_right = v[23:0];
    tx_valid = 1'b1;
    while (1) begin
      ok = tx_ready;
      @(negedge clk);
      if (ok) break;
    end
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx();
    while (!rx_valid) @(negedge clk);
  endtask

  // Independent serial monitor: counts bit slots from the first falling sclk edge.
  bit mon_on = 1'b0, prev_sclk = 1'b0;
  int mon_cnt = 0;
  logic [31:0] mon_sh = '0;
  always @(negedge clk) begin
    if (rst) begin
      mon_on = 1'b0; mon_cnt = 0; prev_sclk = 1'b0;
    end else begin
      if (prev_sclk && !sclk) mon_on = 1'b1;
      if (!prev_sclk && sclk && mon_on) begin
        automatic int pos = mon_cnt % 32;
        automatic int ch  = (mon_cnt / 32) % 2;
        automatic int f   = mon_cnt / 64;
        mon_sh = {mon_sh[30:0], sdo};
        if (pos == 0 && f < NV) chk(ws == ch[0], "R3 ws half", 64'(ws), 64'(ch));
        if (pos == 0 && ch == 1 && f < 2)
          chk(fsync == (f == 0), "R6 fsync frame", 64'(fsync), 64'(f == 0));
        if (pos == 31 && f < NV) begin
          automatic logic [31:0] e = {1'b0, (ch == 1) ? VEC[f][23:0] : VEC[f][47:24], 7'b0};
          chk(mon_sh == e, "R4 R3 half-word layout", 64'(mon_sh), 64'(e));
        end
        mon_cnt++;
      end
      prev_sclk = sclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state, R1 sclk idle while ce low
    chk({sclk, ws, sdo, fsync, rx_valid, underrun} == 6'b0, "R10 reset outputs",
        64'({sclk, ws, sdo, fsync, rx_valid, underrun}), 64'h0);
    chk(tx_ready == 1'b1 && rx_band == 5'd0, "R10 ready/band", 64'({tx_ready, rx_band}), 64'h20);
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R1 sclk holds without ce", 64'(sclk), 64'h0);

    push(VEC[0]);
    chk(tx_ready == 1'b0, "R7 holding register full", 64'(tx_ready), 64'h0);
    ce = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R1 first enable is rising edge", 64'(sclk), 64'h1);

    fork
      for (int i = 1; i < NV; i++) push(VEC[i]);
      for (int k = 0; k < NV; k++) begin
        wait_rx();
        chk({rx_left, rx_right} == VEC[k], "R5 loopback pair", 64'({rx_left, rx_right}), 64'(VEC[k]));
        chk(rx_band == 5'(k), "R6 band index", 64'(rx_band), 64'(k));
        if (k == NV - 1) chk(underrun == 1'b0, "R8 no underrun while fed", 64'(underrun), 64'h0);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R9 handshake clears valid", 64'(rx_valid), 64'h0);
      end
    join

    // R8: no new pair -> repeat and sticky flag
    wait_rx();
    chk({rx_left, rx_right} == VEC[NV-1], "R8 repeated pair", 64'({rx_left, rx_right}), 64'(VEC[NV-1]));
    chk(underrun == 1'b1 && rx_band == 5'(NV), "R8 underrun set", 64'({underrun, rx_band}), 64'({1'b1, 5'(NV)}));
    @(negedge clk);

    // R9 back-pressure
    rx_ready = 1'b0;
    wait_rx();
    chk(rx_band == 5'(NV + 1), "R9 held pair band", 64'(rx_band), 64'(NV + 1));
    repeat (60) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_band == 5'(NV + 1), "R9 pair holds", 64'({rx_valid, rx_band}), 64'({1'b1, 5'(NV + 1)}));
    while (rx_band == 5'(NV + 1)) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_band == 5'(NV + 2), "R9 replaced by next pair", 64'({rx_valid, rx_band}), 64'({1'b1, 5'(NV + 2)}));
    rx_ready = 1'b1;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9 taken after ready", 64'(rx_valid), 64'h0);
    chk(underrun == 1'b1, "R8 flag still sticky", 64'(underrun), 64'h1);

    // R6 wrap of the sub-band index
    while (1) begin
      wait_rx();
      if (rx_band == 5'd31) break;
      @(negedge clk);
    end
    chk(fsync == 1'b0, "R6 fsync low in band 31", 64'(fsync), 64'h0);
    @(negedge clk);
    while (ws) @(negedge clk);
    while (!ws) @(negedge clk);
    chk(fsync == 1'b1, "R6 fsync high in band 0", 64'(fsync), 64'h1);
    wait_rx();
    chk(rx_band == 5'd0, "R6 index wraps to 0", 64'(rx_band), 64'h0);
    @(negedge clk);
    while (ws) @(negedge clk);
    while (!ws) @(negedge clk);
    chk(fsync == 1'b0, "R6 fsync low in band 1", 64'(fsync), 64'h0);

    // R10 reset again mid-run
    rst = 1'b1;
    ce  = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({sclk, ws, sdo, fsync, rx_valid, underrun} == 6'b0, "R10 reset clears state",
        64'({sclk, ws, sdo, fsync, rx_valid, underrun}), 64'h0);
    chk(tx_ready == 1'b1 && rx_band == 5'd0, "R10 ready and band after reset", 64'({tx_ready, rx_band}), 64'h20);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule